// File: doc/BRIEF.md
# Prefixed Instruction Byte Collector

This block is the sequential front end of an 8-bit processor's decoder. A fetch port offers it one instruction byte on each cycle where the byte strobe is high. The collector absorbs any index-prefix bytes (0xDD for the X index register, 0xFD for the Y index register) and then takes the opcode. It then gathers however many further bytes that opcode needs: a signed displacement for an indexed memory operand, then a one- or two-byte immediate.

When the last byte of an instruction has been taken, the collector raises a one-cycle ready pulse. With that pulse it presents a decoded bundle: the opcode, its three register fields, the index selection, the sign-extended displacement, the 16-bit immediate, move and halt flags, and the number of bytes the instruction used. The surrounding pipeline latches the bundle on the ready cycle. The fetch side may leave gaps of any length between bytes.

Top module: `prefixed_byte_collector`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) drops the ready output and discards any partial instruction and pending prefix. The first plain opcode after reset reports index code 00 and a length of 1.
- R2: A prefix byte seen where an opcode is expected is not reported as an instruction. 0xDD sets index code 01 and 0xFD sets index code 10. With no prefix the index code is 00.
- R3: When several prefix bytes arrive in a row, only the last one decides the index code.
- R4: Opcodes 0x01, 0x11, 0x21, 0x31, 0x22, 0x2A, 0x32, 0x3A and 0xC3 take two operand bytes. The first byte goes to imm[7:0] and the second to imm[15:8].
- R5: Opcodes with bits 7:6 = 00 and bits 2:0 = 110, and opcodes 0x10 and 0x18, take one operand byte. That byte goes to imm[7:0] and imm[15:8] reads 0. All other opcodes take no operand byte and report imm = 0.
- R6: Under a prefix, one displacement byte follows the opcode, ahead of any immediate byte, when the opcode names the memory code 110 in an operand field. This covers 0x34, 0x35 and 0x36; opcodes 01xxxxxx other than 0x76 with 110 in bits 5:3 or bits 2:0; and opcodes 10xxx110. The instruction then reports mem_indexed = 1 and disp_ext equal to the displacement sign-extended to 16 bits. Otherwise it reports mem_indexed = 0 and disp_ext = 0.
- R7: Without a prefix, the memory code 110 causes no displacement byte to be collected.
- R8: dst_reg shows opcode bits 5:3, src_reg shows bits 2:0 and pair_sel shows bits 5:4. is_move is 1 for opcodes with bits 7:6 = 01 except 0x76. 0x76 sets is_halt instead.
- R9: instr_ready is high for exactly the one cycle after the clock edge that accepts an instruction's final byte. It is low in every other cycle, including cycles without a byte strobe, which leave the collection state unchanged.
- R10: instr_len counts every byte of the instruction, superseded prefixes included, and saturates at 2^LEN_W-1.
- R11: The prefix is used up by the instruction it precedes. The next unprefixed instruction reports index code 00 and collects no displacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | Byte strobe from the fetch port |
| byte_in | input | 8 | Instruction byte |
| instr_ready | output | 1 | One-cycle pulse: bundle valid |
| instr_len | output | LEN_W | Bytes used by the instruction, saturating |
| opcode | output | 8 | Opcode byte |
| index_sel | output | 2 | 00 none, 01 X index, 10 Y index |
| dst_reg | output | 3 | Opcode bits 5:3 |
| src_reg | output | 3 | Opcode bits 2:0 |
| pair_sel | output | 2 | Opcode bits 5:4 |
| is_move | output | 1 | Register-to-register move |
| is_halt | output | 1 | Opcode 0x76 |
| mem_indexed | output | 1 | Displacement byte was collected |
| disp_ext | output | 16 | Sign-extended displacement |
| imm | output | 16 | Immediate operand |

## Verification
Every result of this block is due in the cycle after the clock edge that accepts the final byte of an instruction. Before that edge, no partial result counts.

The bench drives each byte at a falling edge and samples at the next falling edge. That sample point sees exactly one rising edge and so exactly one register stage. At that point the bench expects ready high and checks the full bundle when the byte was the last one, and expects ready low after every prefix, displacement or first-immediate byte and after every idle gap cycle. Instructions are random, with zero to two prefixes and random gaps. Directed sequences cover saturation, reset in the middle of a prefix, and prefix replacement.

// File: rtl/collector_pkg.sv
// Shared types and opcode-shape helpers for the byte collector.
// Assumes an 8-bit opcode map with two index-prefix codes.
package collector_pkg;

    typedef enum logic [1:0] {
        IDX_NONE = 2'd0,
        IDX_X    = 2'd1,
        IDX_Y    = 2'd2
    } idx_e;

    typedef enum logic [1:0] {
        ST_OPC  = 2'd0,
        ST_DISP = 2'd1,
        ST_IMLO = 2'd2,
        ST_IMHI = 2'd3
    } col_st_e;

    localparam logic [7:0] PFX_X    = 8'hDD;
    localparam logic [7:0] PFX_Y    = 8'hFD;
    localparam logic [7:0] OP_HALT  = 8'h76;
    localparam logic [2:0] MEM_CODE = 3'b110;

    // Number of immediate bytes following an opcode (0, 1 or 2).
    function automatic logic [1:0] imm_bytes(input logic [7:0] op);
        logic [1:0] n;
        n = 2'd0;
        if (op[7:6] == 2'b00 && op[3:0] == 4'b0001)
            n = 2'd2;
        else if (op == 8'h22 || op == 8'h2A || op == 8'h32 ||
                 op == 8'h3A || op == 8'hC3)
            n = 2'd2;
        else if (op[7:6] == 2'b00 && op[2:0] == MEM_CODE)
            n = 2'd1;
        else if (op == 8'h10 || op == 8'h18)
            n = 2'd1;
        return n;
    endfunction

    // True when an opcode addresses memory through the pointer code.
    function automatic logic names_mem(input logic [7:0] op);
        logic hit;
        case (op[7:6])
            2'b00:   hit = (op[5:3] == MEM_CODE) &&
                           (op[2:0] == 3'b100 || op[2:0] == 3'b101 ||
                            op[2:0] == 3'b110);
            2'b01:   hit = (op != OP_HALT) &&
                           (op[5:3] == MEM_CODE || op[2:0] == MEM_CODE);
            2'b10:   hit = (op[2:0] == MEM_CODE);
            default: hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pfx_tracker.sv
// Pending index-prefix register.
// Assumes set and clear requests never arrive in the same cycle;
// a later prefix overwrites an earlier one.
module pfx_tracker
    import collector_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_x,
    input  logic set_y,
    input  logic clear,
    output idx_e pend
);

    // Hold the most recent prefix until its instruction completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= IDX_NONE;
        else if (set_x)
            pend <= IDX_X;
        else if (set_y)
            pend <= IDX_Y;
        else if (clear)
            pend <= IDX_NONE;
    end

endmodule

// File: rtl/op_classifier.sv
// Combinational sizing of an incoming opcode: whether a displacement
// byte follows and how many immediate bytes follow.
// Assumes the caller only uses the result on an opcode byte.
module op_classifier
    import collector_pkg::*;
(
    input  logic [7:0] op,
    input  logic       prefixed,
    output logic       need_disp,
    output logic [1:0] n_imm
);

    // Size the operand tail from the opcode pattern.
    always_comb begin
        need_disp = prefixed && names_mem(op);
        n_imm     = imm_bytes(op);
    end

endmodule

// File: rtl/byte_tally.sv
// Saturating byte counter for one instruction; publishes the total
// when the final byte is taken. Assumes finish implies bump.
module byte_tally #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    input  logic             finish,
    output logic [LEN_W-1:0] len_q
);

    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] cnt_inc;

    // Saturating increment of the running count.
    always_comb cnt_inc = (cnt == LEN_MAX) ? cnt : cnt + 1'b1;

    // Count bytes; publish and restart at instruction end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            len_q <= '0;
        end else if (finish) begin
            cnt   <= '0;
            len_q <= cnt_inc;
        end else if (bump) begin
            cnt   <= cnt_inc;
        end
    end

endmodule

// File: rtl/prefixed_byte_collector.sv
// Instruction byte collector: absorbs index prefixes, takes the opcode,
// then a displacement and/or immediate bytes, and pulses instr_ready
// for one cycle with the decoded bundle. Assumes one byte per strobe
// and that the consumer samples the bundle in the ready cycle.
module prefixed_byte_collector
    import collector_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic [7:0]       byte_in,
    output logic             instr_ready,
    output logic [LEN_W-1:0] instr_len,
    output logic [7:0]       opcode,
    output logic [1:0]       index_sel,
    output logic [2:0]       dst_reg,
    output logic [2:0]       src_reg,
    output logic [1:0]       pair_sel,
    output logic             is_move,
    output logic             is_halt,
    output logic             mem_indexed,
    output logic [15:0]      disp_ext,
    output logic [15:0]      imm
);

    col_st_e     st;
    idx_e        pend;
    idx_e        idx_q;
    logic [7:0]  op_q;
    logic [7:0]  disp_q;
    logic [15:0] imm_q;
    logic        mem_q;
    logic [1:0]  n_imm_q;
    logic        ready_q;

    logic        pfx_x, pfx_y, take_op, finish;
    logic        need_disp_c;
    logic [1:0]  n_imm_c;

    pfx_tracker u_pfx (
        .clk   (clk),
        .rst_n (rst_n),
        .set_x (pfx_x),
        .set_y (pfx_y),
        .clear (finish),
        .pend  (pend)
    );

    op_classifier u_cls (
        .op        (byte_in),
        .prefixed  (pend != IDX_NONE),
        .need_disp (need_disp_c),
        .n_imm     (n_imm_c)
    );

    byte_tally #(.LEN_W(LEN_W)) u_tally (
        .clk    (clk),
        .rst_n  (rst_n),
        .bump   (byte_valid),
        .finish (finish),
        .len_q  (instr_len)
    );

    // Classify the accepted byte and detect the final byte.
    always_comb begin
        pfx_x   = (st == ST_OPC) && byte_valid && (byte_in == PFX_X);
        pfx_y   = (st == ST_OPC) && byte_valid && (byte_in == PFX_Y);
        take_op = (st == ST_OPC) && byte_valid && !pfx_x && !pfx_y;
        case (st)
            ST_OPC:  finish = take_op && !need_disp_c && (n_imm_c == 2'd0);
            ST_DISP: finish = byte_valid && (n_imm_q == 2'd0);
            ST_IMLO: finish = byte_valid && (n_imm_q == 2'd1);
            default: finish = byte_valid;
        endcase
    end

    // Collection state machine and operand capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_OPC;
            idx_q   <= IDX_NONE;
            op_q    <= '0;
            disp_q  <= '0;
            imm_q   <= '0;
            mem_q   <= 1'b0;
            n_imm_q <= '0;
        end else if (byte_valid) begin
            case (st)
                ST_OPC: if (take_op) begin
                    op_q    <= byte_in;
                    idx_q   <= pend;
                    disp_q  <= '0;
                    imm_q   <= '0;
                    mem_q   <= need_disp_c;
                    n_imm_q <= n_imm_c;
                    if (need_disp_c)
                        st <= ST_DISP;
                    else if (n_imm_c != 2'd0)
                        st <= ST_IMLO;
                end
                ST_DISP: begin
                    disp_q <= byte_in;
                    st     <= (n_imm_q != 2'd0) ? ST_IMLO : ST_OPC;
                end
                ST_IMLO: begin
                    imm_q[7:0] <= byte_in;
                    st         <= (n_imm_q == 2'd2) ? ST_IMHI : ST_OPC;
                end
                default: begin
                    imm_q[15:8] <= byte_in;
                    st          <= ST_OPC;
                end
            endcase
        end
    end

    // One-cycle ready pulse following the final byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready_q <= 1'b0;
        else
            ready_q <= finish;
    end

    // Field extraction from the held opcode and operands.
    always_comb begin
        instr_ready = ready_q;
        opcode      = op_q;
        index_sel   = idx_q;
        dst_reg     = op_q[5:3];
        src_reg     = op_q[2:0];
        pair_sel    = op_q[5:4];
        is_halt     = (op_q == OP_HALT);
        is_move     = (op_q[7:6] == 2'b01) && (op_q != OP_HALT);
        mem_indexed = mem_q;
        disp_ext    = {{8{disp_q[7]}}, disp_q};
        imm         = imm_q;
    end

endmodule

// File: rtl/pbc_checker.sv
// Port-level properties of the collector, bound to every instance.
module pbc_checker #(
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_valid,
    input logic             instr_ready,
    input logic [LEN_W-1:0] instr_len,
    input logic [1:0]       index_sel,
    input logic             is_move,
    input logic             is_halt,
    input logic             mem_indexed
);

    // R1: first cycle after reset shows no instruction
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !instr_ready);

    // R9: a ready pulse always follows an accepted byte
    a_r9_ready_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        instr_ready |-> $past(byte_valid));

    // R2: index code stays within its three legal values
    a_r2_index_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        instr_ready |-> index_sel != 2'b11);

    // R6: a displacement only exists under a prefix
    a_r6_disp_needs_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_ready && mem_indexed) |-> index_sel != 2'b00);

    // R8: move and halt never coincide
    a_r8_move_halt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        instr_ready |-> !(is_move && is_halt));

    // R10: a prefixed instruction spans at least two bytes
    a_r10_len_floor: assert property (@(posedge clk) disable iff (!rst_n)
        instr_ready |-> (instr_len != '0) && (index_sel == 2'b00 || instr_len >= 2));

endmodule

bind prefixed_byte_collector pbc_checker #(.LEN_W(LEN_W)) u_pbc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_valid  (byte_valid),
    .instr_ready (instr_ready),
    .instr_len   (instr_len),
    .index_sel   (index_sel),
    .is_move     (is_move),
    .is_halt     (is_halt),
    .mem_indexed (mem_indexed)
);

// File: tb/prefixed_byte_collector_bench.sv
// Self-checking bench: random instruction streams plus directed cases.
module prefixed_byte_collector_bench;

    localparam int LEN_W = 4;
    localparam int LEN_MAX = (1 << LEN_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             byte_valid = 1'b0;
    logic [7:0]       byte_in = 8'h00;
    logic             instr_ready;
    logic [LEN_W-1:0] instr_len;
    logic [7:0]       opcode;
    logic [1:0]       index_sel;
    logic [2:0]       dst_reg, src_reg;
    logic [1:0]       pair_sel;
    logic             is_move, is_halt, mem_indexed;
    logic [15:0]      disp_ext, imm;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    prefixed_byte_collector #(.LEN_W(LEN_W)) u_prefixed_byte_collector (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
        .instr_ready(instr_ready), .instr_len(instr_len), .opcode(opcode),
        .index_sel(index_sel), .dst_reg(dst_reg), .src_reg(src_reg),
        .pair_sel(pair_sel), .is_move(is_move), .is_halt(is_halt),
        .mem_indexed(mem_indexed), .disp_ext(disp_ext), .imm(imm)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected immediate byte count, from R4 and R5.
    function automatic int ref_imm_n(input logic [7:0] op);
        case (op)
            8'h01, 8'h11, 8'h21, 8'h31, 8'h22, 8'h2A, 8'h32, 8'h3A, 8'hC3: return 2;
            8'h06, 8'h0E, 8'h16, 8'h1E, 8'h26, 8'h2E, 8'h36, 8'h3E, 8'h10, 8'h18: return 1;
            default: return 0;
        endcase
    endfunction

    // Expected displacement presence, from R6 and R7.
    function automatic bit ref_disp(input logic [7:0] op, input int pf);
        if (pf == 0) return 0;
        if (op == 8'h34 || op == 8'h35 || op == 8'h36) return 1;
        if (op >= 8'h40 && op <= 8'h7F && op != 8'h76)
            return (op[5:3] == 3'd6) || (op[2:0] == 3'd6);
        if (op >= 8'h80 && op <= 8'hBF) return op[2:0] == 3'd6;
        return 0;
    endfunction

    // One idle cycle: no strobe, ready must be low (R9).
    task automatic idle_cycle();
        byte_valid = 1'b0;
        @(negedge clk);
        check("R9 idle ready", instr_ready, 0);
    endtask

    // Drive one byte, sample after its edge.
    task automatic feed(input logic [7:0] b, input bit last, input int max_gap);
        int gap;
        gap = (max_gap > 0) ? int'($urandom_range(max_gap, 0)) : 0;
        for (int g = 0; g < gap; g++) idle_cycle();
        byte_valid = 1'b1;
        byte_in    = b;
        @(negedge clk);
        byte_valid = 1'b0;
        if (!last) check("R9 ready low mid-instruction", instr_ready, 0);
    endtask

    // Send prefixes, opcode and operands; check the bundle.
    task automatic run_instr(input logic [7:0] pfx[$], input logic [7:0] op,
                             input logic [7:0] d, input logic [15:0] iv,
                             input int max_gap);
        int pf, ni, len;
        bit hd;
        logic [15:0] e_imm;
        pf = 0;
        foreach (pfx[k]) pf = (pfx[k] == 8'hDD) ? 1 : 2;
        ni = ref_imm_n(op);
        hd = ref_disp(op, pf);
        len = pfx.size() + 1 + (hd ? 1 : 0) + ni;
        if (len > LEN_MAX) len = LEN_MAX;
        e_imm = (ni == 2) ? iv : (ni == 1) ? {8'h00, iv[7:0]} : 16'h0000;
        foreach (pfx[k]) feed(pfx[k], 1'b0, max_gap);
        feed(op, (ni == 0) && !hd, max_gap);
        if (hd) feed(d, ni == 0, max_gap);
        if (ni >= 1) feed(iv[7:0], ni == 1, max_gap);
        if (ni == 2) feed(iv[15:8], 1'b1, max_gap);
        check("R9 ready pulse", instr_ready, 1);
        check("R2 R3 R11 index code", index_sel, pf);
        check("R10 length", instr_len, len);
        check("R8 opcode", opcode, op);
        check("R8 fields", {dst_reg, src_reg, pair_sel}, {op[5:3], op[2:0], op[5:4]});
        check("R8 move/halt", {is_move, is_halt},
              {(op[7:6] == 2'b01) && (op != 8'h76), op == 8'h76});
        check("R6 R7 mem_indexed", mem_indexed, hd);
        check("R6 disp_ext", disp_ext, hd ? {{8{d[7]}}, d} : 16'h0000);
        check("R4 R5 immediate", imm, e_imm);
        idle_cycle();
    endtask

    initial begin
        logic [7:0] pq[$];
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 ready in reset", instr_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", instr_ready, 0);

        // Directed corner cases
        pq = {};             run_instr(pq, 8'h00, 8'h00, 16'h0000, 0); // R1 plain
        pq = {8'hDD};        run_instr(pq, 8'h46, 8'h80, 16'h0000, 0); // R6 negative disp
        pq = {};             run_instr(pq, 8'h46, 8'h00, 16'h0000, 0); // R7 R11
        pq = {8'hDD, 8'hFD}; run_instr(pq, 8'h36, 8'h7F, 16'h00A5, 1); // R3 R6 disp then imm
        pq = {8'hFD};        run_instr(pq, 8'h21, 8'h00, 16'hBEEF, 0); // R4 pair immediate
        pq = {};             run_instr(pq, 8'hC3, 8'h00, 16'h1234, 2); // R4 jump
        pq = {};             run_instr(pq, 8'h18, 8'h00, 16'h00FE, 0); // R5
        pq = {8'hDD};        run_instr(pq, 8'h76, 8'h00, 16'h0000, 0); // R8 halt, no disp
        pq = {};             run_instr(pq, 8'h41, 8'h00, 16'h0000, 0); // R8 move
        pq = {};
        for (int i = 0; i < 20; i++) pq.push_back((i % 2) ? 8'hFD : 8'hDD);
        run_instr(pq, 8'h00, 8'h00, 16'h0000, 0);                     // R10 saturation

        // R1: reset discards a pending prefix
        feed(8'hDD, 1'b0, 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 ready after mid reset", instr_ready, 0);
        pq = {}; run_instr(pq, 8'h86, 8'h00, 16'h0000, 0);

        // Random stream
        for (int n = 0; n < 400; n++) begin
            logic [7:0] op;
            int np;
            pq = {};
            np = $urandom_range(2, 0);
            for (int k = 0; k < np; k++) pq.push_back($urandom_range(1, 0) ? 8'hDD : 8'hFD);
            do op = 8'($urandom); while (op == 8'hDD || op == 8'hFD);
            run_instr(pq, op, 8'($urandom), 16'($urandom), 2);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule